// File: doc/BRIEF.md
# Accumulator with Carry Register

This block is the arithmetic working register of a small processor datapath. It keeps an accumulator word and a one-bit carry flag. A three-bit operation code picks what happens to the accumulator on each rising clock edge: it can keep its value, take the operand word, add the operand plus the stored carry, apply a bitwise AND, OR or XOR with the operand, invert itself, or clear. The operand comes bit for bit from a data register elsewhere in the datapath.

Each accumulator bit is a single flip-flop behind an eight-way function multiplexer. The hold function feeds the flip-flop's own output back through that multiplexer, so the accumulator has no load enable. The carry flag takes the adder's carry-out only on an add; every other code leaves it unchanged. A synchronous clear input zeroes both registers, and a combinational zero output reports an all-zero accumulator. The control unit that produces the operation code is outside this block.

Top module: `acc_carry_unit`

## Requirements
- R1: While `rst_n` is low, `acc_q` is 0 and `carry_q` is 0. Reset is asserted asynchronously and released in step with the clock.
- R2: With code 3'b000 (hold) and `clr` low, `acc_q` keeps its value across the edge.
- R3: With code 3'b001 (load) and `clr` low, `acc_q` takes `opnd` on the edge.
- R4: With code 3'b010 (add) and `clr` low, `acc_q` becomes (`acc_q` + `opnd` + `carry_q`) mod 2^WIDTH and `carry_q` takes the carry-out of that sum.
- R5: Codes 3'b011, 3'b100 and 3'b101 load `acc_q` with the bitwise AND, OR and XOR of `acc_q` and `opnd`.
- R6: Code 3'b110 loads `acc_q` with the bitwise complement of `acc_q`.
- R7: Code 3'b111 loads `acc_q` with 0 and leaves `carry_q` unchanged.
- R8: For every code other than 3'b010, `carry_q` keeps its value across the edge.
- R9: When `clr` is high on an edge, both `acc_q` and `carry_q` become 0, whatever the code.
- R10: `zero` is high exactly when every bit of `acc_q` is 0, with no clock delay.
- R11: An add starting from all ones with operand 0 and `carry_q` at 1 wraps `acc_q` to 0 and sets `carry_q` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| clr | input | 1 | Synchronous clear of accumulator and carry, active high |
| op | input | 3 | Operation code |
| opnd | input | WIDTH | Operand word from the data register |
| acc_q | output | WIDTH | Accumulator value |
| carry_q | output | 1 | Carry flag |
| zero | output | 1 | High when the accumulator is all zeros |

## Verification
The bench builds the block with its defaults, an 8-bit word and a two-stage reset synchronizer. At that width a single load reaches the all-ones value, so the full carry ripple through every bit and the wrap to zero with carry-out set are each one operation away. Every code is driven from several starting values and operands, with the carry flag both set and clear, and each result is compared against a model kept in the bench.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'b000,
    OP_LOAD = 3'b001,
    OP_ADD  = 3'b010,
    OP_AND  = 3'b011,
    OP_OR   = 3'b100,
    OP_XOR  = 3'b101,
    OP_INV  = 3'b110,
    OP_ZERO = 3'b111
  } acc_op_e;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

  // R1
  rst_assert_chk: assert property (@(posedge clk) !rst_n |=> !rst_sync_n)
    else $error("synchronized reset did not follow rst_n low");

endmodule

// File: rtl/acc_ripple_adder.sv
module acc_ripple_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic p;
    assign p          = a[i] ^ b[i];
    assign sum[i]     = p ^ chain[i];
    assign chain[i+1] = (a[i] & b[i]) | (p & chain[i]);
  end

  assign cout = chain[WIDTH];

  // R4
  always_comb begin
    adder_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("ripple adder result disagrees with arithmetic sum");
  end

endmodule

// File: rtl/acc_func_mux.sv
module acc_func_mux
  import acc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  acc_op_e          op,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] opnd,
  input  logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] nxt
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (op)
        OP_HOLD: nxt[i] = acc[i];
        OP_LOAD: nxt[i] = opnd[i];
        OP_ADD:  nxt[i] = sum[i];
        OP_AND:  nxt[i] = acc[i] & opnd[i];
        OP_OR:   nxt[i] = acc[i] | opnd[i];
        OP_XOR:  nxt[i] = acc[i] ^ opnd[i];
        OP_INV:  nxt[i] = ~acc[i];
        OP_ZERO: nxt[i] = 1'b0;
        default: nxt[i] = acc[i];
      endcase
    end
  end

endmodule

// File: rtl/acc_carry_unit.sv
module acc_carry_unit
  import acc_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] opnd,
  output logic [WIDTH-1:0] acc_q,
  output logic             carry_q,
  output logic             zero
);

  acc_op_e          op_e;
  logic             rst_sync_n;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic [WIDTH-1:0] mux_out;
  logic [WIDTH-1:0] acc_d;
  logic             carry_d;
  logic             carry_en;

  assign op_e = acc_op_e'(op);

  acc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_ripple_adder #(.WIDTH(WIDTH)) u_add (
    .a    (acc_q),
    .b    (opnd),
    .cin  (carry_q),
    .sum  (sum),
    .cout (cout)
  );

  acc_func_mux #(.WIDTH(WIDTH)) u_mux (
    .op   (op_e),
    .acc  (acc_q),
    .opnd (opnd),
    .sum  (sum),
    .nxt  (mux_out)
  );

  // next-state
  always_comb begin
    acc_d    = clr ? '0 : mux_out;
    carry_en = clr | (op_e == OP_ADD);
    carry_d  = clr ? 1'b0 : cout;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) acc_q <= '0;
    else             acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   carry_q <= 1'b0;
    else if (carry_en) carry_q <= carry_d;
  end

  assign zero = ~|acc_q;

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr && op == 3'b000) |=> $stable(acc_q))
    else $error("accumulator changed on hold");

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr && op == 3'b001) |=> (acc_q == $past(opnd)))
    else $error("accumulator did not take operand on load");

  // R8
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr && op != 3'b010) |=> $stable(carry_q))
    else $error("carry changed on a non-add code");

  // R9
  clr_both_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> (acc_q == '0 && !carry_q))
    else $error("clear did not zero both registers");

  // R7
  zero_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op == 3'b111) |=> zero)
    else $error("zeroing code left accumulator nonzero");

endmodule

// File: tb/tb_acc_carry_unit.sv
module tb_acc_carry_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr;
  logic [2:0] op;
  logic [7:0] opnd;
  logic [7:0] acc_q;
  logic       carry_q;
  logic       zero;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m_acc;
  logic       m_c;

  always #2 clk = ~clk;

  acc_carry_unit dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .op(op), .opnd(opnd),
    .acc_q(acc_q), .carry_q(carry_q), .zero(zero)
  );

  task automatic check(input string tag, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [7:0] d,
                       input logic c, input string tag);
    logic [7:0] ea;
    logic       ec;
    logic [8:0] s9;
    @(negedge clk);
    op = o; opnd = d; clr = c;
    s9 = {1'b0, m_acc} + {1'b0, d} + {8'd0, m_c};
    ea = m_acc; ec = m_c;
    if (c) begin
      ea = 8'h00; ec = 1'b0;
    end else begin
      case (o)
        3'b000: ea = m_acc;
        3'b001: ea = d;
        3'b010: begin ea = s9[7:0]; ec = s9[8]; end
        3'b011: ea = m_acc & d;
        3'b100: ea = m_acc | d;
        3'b101: ea = m_acc ^ d;
        3'b110: ea = ~m_acc;
        default: ea = 8'h00;
      endcase
    end
    @(posedge clk); #1;
    m_acc = ea; m_c = ec;
    check(tag, "acc", {1'b0, acc_q}, {1'b0, ea});
    check(tag, "carry", {8'd0, carry_q}, {8'd0, ec});
    check({tag, "/R10"}, "zero", {8'd0, zero}, {8'd0, (ea == 8'h00)});
  endtask

  task automatic test_reset;
    rst_n = 1'b0; clr = 1'b0; op = 3'b000; opnd = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "acc", {1'b0, acc_q}, 9'h000);
    check("R1", "carry", {8'd0, carry_q}, 9'h000);
    check("R10", "zero", {8'd0, zero}, 9'h001);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    m_acc = 8'h00; m_c = 1'b0;
    check("R1", "acc after release", {1'b0, acc_q}, 9'h000);
  endtask

  task automatic test_load_hold;
    apply(3'b001, 8'hA5, 1'b0, "R3");
    apply(3'b000, 8'h3C, 1'b0, "R2");
    apply(3'b000, 8'hFF, 1'b0, "R2");
    apply(3'b001, 8'h00, 1'b0, "R3");
    apply(3'b001, 8'h81, 1'b0, "R3");
  endtask

  task automatic test_add;
    apply(3'b001, 8'h0F, 1'b0, "R3");
    apply(3'b010, 8'h01, 1'b0, "R4");
    apply(3'b010, 8'hF0, 1'b0, "R4");
    apply(3'b010, 8'h01, 1'b0, "R4");
    apply(3'b010, 8'h10, 1'b0, "R4");
    apply(3'b001, 8'h7F, 1'b0, "R8");
    apply(3'b010, 8'h80, 1'b0, "R4");
  endtask

  task automatic test_wrap;
    apply(3'b001, 8'hFF, 1'b0, "R3");
    apply(3'b010, 8'h01, 1'b0, "R4");
    apply(3'b001, 8'hFF, 1'b0, "R8");
    apply(3'b010, 8'h00, 1'b0, "R11");
    apply(3'b010, 8'h00, 1'b0, "R4");
  endtask

  task automatic test_logic;
    apply(3'b001, 8'hCC, 1'b0, "R3");
    apply(3'b011, 8'hAA, 1'b0, "R5");
    apply(3'b100, 8'h55, 1'b0, "R5");
    apply(3'b101, 8'hF0, 1'b0, "R5");
    apply(3'b011, 8'h00, 1'b0, "R5");
    apply(3'b100, 8'h3C, 1'b0, "R5");
    apply(3'b101, 8'h3C, 1'b0, "R5");
  endtask

  task automatic test_invert;
    apply(3'b001, 8'h96, 1'b0, "R3");
    apply(3'b110, 8'h00, 1'b0, "R6");
    apply(3'b110, 8'hFF, 1'b0, "R6");
  endtask

  task automatic test_zero_code;
    apply(3'b001, 8'hFF, 1'b0, "R3");
    apply(3'b010, 8'h01, 1'b0, "R4");
    apply(3'b111, 8'h5A, 1'b0, "R7");
    apply(3'b001, 8'h42, 1'b0, "R8");
    apply(3'b110, 8'h00, 1'b0, "R8");
  endtask

  task automatic test_clr;
    apply(3'b001, 8'hFF, 1'b0, "R3");
    apply(3'b010, 8'h02, 1'b0, "R4");
    apply(3'b010, 8'hFF, 1'b1, "R9");
    apply(3'b001, 8'h77, 1'b1, "R9");
    apply(3'b000, 8'h00, 1'b0, "R2");
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    test_load_hold();
    test_add();
    test_wrap();
    test_logic();
    test_invert();
    test_zero_code();
    test_clr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule